// File: doc/BRIEF.md
# MDIO Management Master with Link Autopoll

This block is a Clause 22 MDIO management master driven through one 32-bit control word and one 32-bit status word. Software writes the control word with the start bit set to send a single read or write frame to an external PHY. The block derives MDC from its own clock, shifts the frame out on MDIO, samples read data, and writes that data back into the low half of the control word. A start flag and a busy flag show how far the transaction has got. The target PHY address is kept in the status word.

When the autopoll enable is set, the block uses the bus itself whenever software has nothing queued. It reads the PHY's basic status register over and over, and compares the link bit with the value from the previous poll. A difference sets a sticky flag that drives the interrupt output, so software does not have to poll the PHY. A software start written while a poll frame is on the bus waits until that frame has finished. A queued software start always goes ahead of the next poll.

Top module: `mdio_autopoll_master`

## Requirements
- R1: While reset is active and in the first cycle after it, both register read ports are zero and `mdc`, `mdio_oe` and `irq` are low.
- R2: A write frame is, MSB first: a preamble of 32 ones, then 01, then the opcode 01, the PHY address (status bits 20:16), the register address (control bits 20:16), the turnaround 10 and the 16 data bits (control bits 15:0). MDIO changes only just after a falling edge of MDC, and every bit lasts one whole MDC period that starts low.
- R3: A read frame (control bit 21 = 1) uses the opcode 10 and drops `mdio_oe` from the first turnaround bit onward. The 16 bits sampled at the rising edges of MDC appear in control bits 15:0 in the cycle in which start and busy clear.
- R4: With control bit 22 set, the preamble is left out and the frame is 32 MDC periods long.
- R5: Clock select (control bits 26:24) code k divides the clock by 4*(k+1) for k from 0 to 6, and code 7 divides it by 28.
- R6: Start (bit 23) reads as 1 from the write that sets it until the frame ends. Busy (bit 27) is 1 exactly while a frame is on the bus. For a software frame, both read 0 from the same cycle. A frame launches at the first clock edge at which start is registered and the bus is idle, and there is at least one idle cycle between frames.
- R7: A write to the control word while start reads 1 has no effect.
- R8: While autopoll (bit 28) is 1 and no start is pending, the block reads register 1 of the PHY at the configured address. It uses the current preamble and clock settings, and polling stops once the enable is cleared.
- R9: When a completed poll returns a value of bit 2 that differs from the stored link state, the flag (status bit 0) and `irq` are set. Status bit 1 shows the latest link state. A poll that returns the same value leaves the flag alone.
- R10: Writing a status word with bit 0 set clears the flag. If a link change completes in the same cycle, the flag stays set.
- R11: A start written during a poll frame is queued. Busy stays 1 until that poll frame ends, and then the software frame runs before any further poll.
- R12: Control bits 30 and 29 are stored and read back unchanged. Bit 31 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, the reference that MDC is divided from |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 32 | Control word write data |
| ctl_rdata | output | 32 | Control word read value, with live start, busy and read data |
| sts_wr | input | 1 | Write strobe for the status word |
| sts_wdata | input | 32 | PHY address in bits 20:16, bit 0 = 1 clears the link-change flag |
| sts_rdata | output | 32 | PHY address, link state (bit 1) and link-change flag (bit 0) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |
| irq | output | 1 | Link-change interrupt, equal to the sticky flag |

## Verification
There are two collisions. The end of a poll frame that reports a link change can land in the same cycle as a software write that clears the flag. A software start can also land while the poll engine owns the bus. The bench uses its reference model's frame schedule to find the last cycle of a poll whose returned link bit has been flipped, and issues the clear write in that cycle. The flag must survive. In a second run, it writes a read command that also clears autopoll in the middle of a poll frame. Start and busy must stay high, the poll must run to its end, and the queued read must follow and return the right data. The model is compared against the ports on every clock, so both collisions are judged cycle by cycle.

// File: rtl/mdio_ap_pkg.sv
// Package: shared field positions, the command record handed to the
// shifter, and the clock-select decode. Assumes Clause 22 frame widths.
package mdio_ap_pkg;

    localparam int PHY_AW  = 5;
    localparam int REG_AW  = 5;
    localparam int DATA_W  = 16;
    localparam int SEL_W   = 3;
    localparam int HALF_W  = 4;

    // control word bit positions
    localparam int CTL_MODE   = 30;
    localparam int CTL_PR     = 29;
    localparam int CTL_AP     = 28;
    localparam int CTL_BUSY   = 27;
    localparam int CTL_SEL_LO = 24;
    localparam int CTL_START  = 23;
    localparam int CTL_SUP    = 22;
    localparam int CTL_RD     = 21;
    localparam int CTL_REG_LO = 16;

    // status word bit positions
    localparam int STS_PHY_LO = 16;
    localparam int STS_LINK   = 1;
    localparam int STS_FLAG   = 0;

    typedef struct packed {
        logic                rd;
        logic                sup;
        logic [SEL_W-1:0]    sel;
        logic [PHY_AW-1:0]   phy;
        logic [REG_AW-1:0]   regad;
        logic [DATA_W-1:0]   data;
    } mdio_cmd_t;

    // MDC half period in clock cycles: 2*(code+1), code 7 capped at 14
    function automatic logic [HALF_W-1:0] half_period(input logic [SEL_W-1:0] sel);
        return (sel == 3'd7) ? 4'd14 : ({sel, 1'b0} + 4'd2);
    endfunction

endpackage

// File: rtl/mdio_ap_clkgen.sv
// MDC generator: while run is high, toggles mdc every `half` cycles,
// starting low, and flags the cycle before each rising and falling edge.
// Assumes half >= 1 and that half is held stable while run is high.
module mdio_ap_clkgen #(
    parameter int HW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [HW-1:0] half,
    output logic          mdc,
    output logic          rise,
    output logic          fall
);

    logic [HW-1:0] cnt_q;
    logic          mdc_q;
    logic          tick;

    assign tick = run && (cnt_q == half - 1'b1);
    assign rise = tick && !mdc_q;
    assign fall = tick && mdc_q;
    assign mdc  = mdc_q;

    // count out the half period and flip mdc at its end
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (tick) begin
            cnt_q <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R5
    mdc_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && !$past(tick)) |-> $stable(mdc));

endmodule

// File: rtl/mdio_ap_shifter.sv
// Frame engine: on launch latches one command, then sends preamble and
// frame bit by bit, driving MDIO after MDC falls and sampling on the rise.
// Assumes launch only arrives while active is low.
module mdio_ap_shifter
    import mdio_ap_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  mdio_cmd_t         cmd,
    input  logic              mdio_i,
    output logic              active,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe
);

    localparam int HDR_LEN   = 4 + PHY_AW + REG_AW;
    localparam int DATA_POS  = HDR_LEN + 2;
    localparam int FRAME_LEN = DATA_POS + DATA_W;
    localparam int IDX_W     = $clog2(PRE_LEN + FRAME_LEN + 1);

    logic                  active_q;
    logic [IDX_W-1:0]      idx_q;
    mdio_cmd_t             cmd_q;
    logic [FRAME_LEN-1:0]  fw_q;
    logic [DATA_W-1:0]     rdata_q;
    logic [IDX_W-1:0]      pre_len, pos, last;
    logic                  in_pre, rise, fall, capture;

    mdio_ap_clkgen #(.HW(HALF_W)) u_clk (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (active_q),
        .half  (half_period(cmd_q.sel)),
        .mdc   (mdc),
        .rise  (rise),
        .fall  (fall)
    );

    // position of the current bit inside preamble or frame
    always_comb begin
        pre_len = cmd_q.sup ? '0 : IDX_W'(PRE_LEN);
        in_pre  = idx_q < pre_len;
        pos     = idx_q - pre_len;
        last    = pre_len + IDX_W'(FRAME_LEN - 1);
        capture = active_q && rise && cmd_q.rd && !in_pre && (pos >= IDX_W'(DATA_POS));
    end

    assign done    = active_q && fall && (idx_q == last);
    assign active  = active_q;
    assign rdata   = rdata_q;
    assign mdio_o  = in_pre | fw_q[FRAME_LEN-1];
    assign mdio_oe = active_q && (in_pre || !cmd_q.rd || (pos < IDX_W'(HDR_LEN)));

    // launch, advance on each MDC fall, stop after the last bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            idx_q    <= '0;
            cmd_q    <= '0;
            fw_q     <= '0;
        end else if (launch) begin
            active_q <= 1'b1;
            idx_q    <= '0;
            cmd_q    <= cmd;
            fw_q     <= {2'b01, (cmd.rd ? 2'b10 : 2'b01), cmd.phy, cmd.regad,
                         (cmd.rd ? 2'b11 : 2'b10),
                         (cmd.rd ? {DATA_W{1'b1}} : cmd.data)};
        end else if (done) begin
            active_q <= 1'b0;
        end else if (active_q && fall) begin
            idx_q <= idx_q + 1'b1;
            if (!in_pre) begin
                fw_q <= {fw_q[FRAME_LEN-2:0], 1'b0};
            end
        end
    end

    // shift in read data at each MDC rise of the data field
    always_ff @(posedge clk) begin
        if (!rst_n || launch) begin
            rdata_q <= '0;
        end else if (capture) begin
            rdata_q <= {rdata_q[DATA_W-2:0], mdio_i};
        end
    end

    // R2
    bus_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && $past(active_q) && !$past(fall)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

endmodule

// File: rtl/mdio_ap_linkwatch.sv
// Link watcher: on each finished poll compares the returned link bit with
// the stored one and keeps a sticky change flag cleared by software.
// Assumes poll_done is a one-cycle pulse.
module mdio_ap_linkwatch (
    input  logic clk,
    input  logic rst_n,
    input  logic poll_done,
    input  logic link_bit,
    input  logic clr,
    output logic flag,
    output logic link
);

    logic flag_q, link_q, set_evt;

    assign set_evt = poll_done && (link_bit != link_q);
    assign flag    = flag_q;
    assign link    = link_q;

    // track link state and the sticky change flag, set beating clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            link_q <= 1'b0;
        end else begin
            if (poll_done) begin
                link_q <= link_bit;
            end
            if (set_evt) begin
                flag_q <= 1'b1;
            end else if (clr) begin
                flag_q <= 1'b0;
            end
        end
    end

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(set_evt) |-> flag_q);

endmodule

// File: rtl/mdio_autopoll_master.sv
// Top: holds the control and status words, decides which frame goes on
// the bus next (queued software start first, then a poll), and routes
// completions back. Assumes software waits for start and busy to clear.
module mdio_autopoll_master
    import mdio_ap_pkg::*;
#(
    parameter int PRE_LEN  = 32,
    parameter int POLL_REG = 1,
    parameter int LINK_BIT = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctl_wr,
    input  logic [31:0] ctl_wdata,
    output logic [31:0] ctl_rdata,
    input  logic        sts_wr,
    input  logic [31:0] sts_wdata,
    output logic [31:0] sts_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i,
    output logic        irq
);

    logic              mode_q, pr_q, ap_q, pend_q, sup_q, rd_q, sw_act_q;
    logic [SEL_W-1:0]  sel_q;
    logic [REG_AW-1:0] reg_q;
    logic [DATA_W-1:0] data_q;
    logic [PHY_AW-1:0] phy_q;
    logic              active, done, launch, poll_done, flag, link;
    logic [DATA_W-1:0] rdata;
    mdio_cmd_t         cmd;

    // choose the next frame: a queued software start beats a poll
    always_comb begin
        launch    = !active && (pend_q || ap_q);
        cmd.rd    = pend_q ? rd_q : 1'b1;
        cmd.sup   = sup_q;
        cmd.sel   = sel_q;
        cmd.phy   = phy_q;
        cmd.regad = pend_q ? reg_q : REG_AW'(POLL_REG);
        cmd.data  = pend_q ? data_q : '0;
    end

    assign poll_done = done && !sw_act_q;

    // control word fields, software writes and transaction completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0; pr_q  <= 1'b0; ap_q  <= 1'b0; pend_q <= 1'b0;
            sup_q  <= 1'b0; rd_q  <= 1'b0; sel_q <= '0;   reg_q  <= '0;
            data_q <= '0;
        end else if (ctl_wr && !pend_q) begin
            mode_q <= ctl_wdata[CTL_MODE];
            pr_q   <= ctl_wdata[CTL_PR];
            ap_q   <= ctl_wdata[CTL_AP];
            sel_q  <= ctl_wdata[CTL_SEL_LO +: SEL_W];
            pend_q <= ctl_wdata[CTL_START];
            sup_q  <= ctl_wdata[CTL_SUP];
            rd_q   <= ctl_wdata[CTL_RD];
            reg_q  <= ctl_wdata[CTL_REG_LO +: REG_AW];
            data_q <= ctl_wdata[DATA_W-1:0];
        end else if (done && sw_act_q) begin
            pend_q <= 1'b0;
            if (rd_q) begin
                data_q <= rdata;
            end
        end
    end

    // remember whether the frame on the bus belongs to software
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_act_q <= 1'b0;
        end else if (launch) begin
            sw_act_q <= pend_q;
        end else if (done) begin
            sw_act_q <= 1'b0;
        end
    end

    // PHY address held in the status word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phy_q <= '0;
        end else if (sts_wr) begin
            phy_q <= sts_wdata[STS_PHY_LO +: PHY_AW];
        end
    end

    mdio_ap_shifter #(.PRE_LEN(PRE_LEN)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch  (launch),
        .cmd     (cmd),
        .mdio_i  (mdio_i),
        .active  (active),
        .done    (done),
        .rdata   (rdata),
        .mdc     (mdc),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe)
    );

    mdio_ap_linkwatch u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .poll_done (poll_done),
        .link_bit  (rdata[LINK_BIT]),
        .clr       (sts_wr && sts_wdata[STS_FLAG]),
        .flag      (flag),
        .link      (link)
    );

    assign irq       = flag;
    assign ctl_rdata = {1'b0, mode_q, pr_q, ap_q, active, sel_q, pend_q,
                        sup_q, rd_q, reg_q, data_q};
    assign sts_rdata = {11'b0, phy_q, 14'b0, link, flag};

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!mdc && !mdio_oe && !irq && ctl_rdata == 32'h0));
    // R6
    start_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_act_q |-> pend_q);
    // R6
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sw_act_q) |-> !pend_q);
    // R11
    queue_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && active && !sw_act_q) |=> pend_q);

endmodule

// File: tb/mdio_autopoll_master_test.sv
module mdio_autopoll_master_test;

    logic        clk = 1'b0;
    logic        rst_n, ctl_wr, sts_wr, mdio_i;
    logic [31:0] ctl_wdata, sts_wdata, ctl_rdata, sts_rdata;
    logic        mdc, mdio_o, mdio_oe, irq;

    always #2 clk = ~clk;

    mdio_autopoll_master uut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .sts_wr(sts_wr), .sts_wdata(sts_wdata),
        .sts_rdata(sts_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .mdio_i(mdio_i), .irq(irq)
    );

    typedef struct packed { logic mdc; logic oe; logic o; logic din; } ent_t;
    ent_t q[$];

    bit        m_mode, m_pr, m_ap, m_pend, m_sup, m_rd, m_active, m_swact;
    bit        m_flag, m_link, m_frd, phy_link, compare_on;
    bit [2:0]  m_sel;
    bit [4:0]  m_reg, m_phy;
    bit [15:0] m_data, m_fval;
    int        total = 0, fails = 0, cyc = 0;

    function automatic bit [15:0] phy_reg_val(input bit [4:0] phy, input bit [4:0] r);
        if (r == 5'd1) return 16'h7809 | {13'b0, phy_link, 2'b0};
        return {r, phy, 6'h2A};
    endfunction

    function automatic bit [31:0] mk(input bit ap, input bit [2:0] sel, input bit start,
                                     input bit sup, input bit rd, input bit [4:0] r,
                                     input bit [15:0] d);
        return {3'b000, ap, 1'b0, sel, start, sup, rd, r, d};
    endfunction

    // schedule one frame, cycle by cycle, as the requirements describe it
    task automatic build(input bit rd, input bit sup, input bit [2:0] sel, input bit [4:0] phy,
                         input bit [4:0] r, input bit [15:0] d, input bit [15:0] val);
        int h = (sel == 3'd7) ? 14 : 2 * (int'(sel) + 1);
        bit [31:0] w = {2'b01, (rd ? 2'b10 : 2'b01), phy, r, (rd ? 2'b00 : 2'b10), (rd ? 16'h0 : d)};
        if (!sup)
            for (int p = 0; p < 32; p++) begin
                for (int k = 0; k < h; k++) q.push_back('{1'b0, 1'b1, 1'b1, 1'b1});
                for (int k = 0; k < h; k++) q.push_back('{1'b1, 1'b1, 1'b1, 1'b1});
            end
        for (int b = 0; b < 32; b++) begin
            bit oe = !(rd && b >= 14);
            bit di = (rd && b >= 16) ? val[31 - b] : 1'b1;
            for (int k = 0; k < h; k++) q.push_back('{1'b0, oe, w[31 - b], di});
            for (int k = 0; k < h; k++) q.push_back('{1'b1, oe, w[31 - b], di});
        end
    endtask

    // reference model, stepped on each rising edge
    always @(posedge clk) begin : model
        bit old_pend, set_f;
        if (!rst_n) begin
            m_mode = 0; m_pr = 0; m_ap = 0; m_pend = 0; m_sup = 0; m_rd = 0;
            m_active = 0; m_swact = 0; m_flag = 0; m_link = 0; m_sel = 0;
            m_reg = 0; m_phy = 0; m_data = 0; q.delete();
        end else begin
            old_pend = m_pend;
            set_f = 0;
            if (m_active) begin
                void'(q.pop_front());
                if (q.size() == 0) begin
                    m_active = 0;
                    if (m_swact) begin
                        m_pend = 0;
                        if (m_frd) m_data = m_fval;
                    end else begin
                        set_f = (m_fval[2] != m_link);
                        m_link = m_fval[2];
                    end
                    m_swact = 0;
                end
            end else if (old_pend || m_ap) begin
                m_frd = old_pend ? m_rd : 1'b1;
                m_fval = phy_reg_val(m_phy, old_pend ? m_reg : 5'd1);
                build(m_frd, m_sup, m_sel, m_phy, old_pend ? m_reg : 5'd1,
                      old_pend ? m_data : 16'h0, m_fval);
                m_active = 1;
                m_swact = old_pend;
            end
            if (ctl_wr && !old_pend) begin
                m_mode = ctl_wdata[30]; m_pr = ctl_wdata[29]; m_ap = ctl_wdata[28];
                m_sel = ctl_wdata[26:24]; m_pend = ctl_wdata[23]; m_sup = ctl_wdata[22];
                m_rd = ctl_wdata[21]; m_reg = ctl_wdata[20:16]; m_data = ctl_wdata[15:0];
            end
            if (sts_wr) m_phy = sts_wdata[20:16];
            if (set_f) m_flag = 1;
            else if (sts_wr && sts_wdata[0]) m_flag = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // compare ports with the model and play the PHY on every falling edge
    always @(negedge clk) begin : compare
        ent_t e;
        e = (m_active && q.size() > 0) ? q[0] : '{1'b0, 1'b0, 1'b1, 1'b1};
        mdio_i = e.din;
        if (compare_on && rst_n) begin
            chk(mdc == e.mdc && mdio_oe == e.oe && (!e.oe || mdio_o == e.o),
                "R2 R3 R5 bus", {29'b0, mdc, mdio_oe, mdio_o}, {29'b0, e.mdc, e.oe, e.o});
            chk(ctl_rdata == {1'b0, m_mode, m_pr, m_ap, m_active, m_sel, m_pend, m_sup, m_rd, m_reg, m_data},
                "R6 control word", ctl_rdata,
                {1'b0, m_mode, m_pr, m_ap, m_active, m_sel, m_pend, m_sup, m_rd, m_reg, m_data});
            chk(sts_rdata == {11'b0, m_phy, 14'b0, m_link, m_flag} && irq == m_flag,
                "R9 status/irq", {sts_rdata[31:1], irq}, {11'b0, m_phy, 14'b0, m_link, m_flag});
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++; total++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    task automatic ctl_put(input bit [31:0] w);
        ctl_wdata = w; ctl_wr = 1'b1;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic sts_put(input bit [31:0] w);
        sts_wdata = w; sts_wr = 1'b1;
        @(negedge clk);
        sts_wr = 1'b0;
    endtask

    task automatic wait_idle(output int busy_cnt);
        busy_cnt = 0;
        while (ctl_rdata[27] || ctl_rdata[23]) begin
            if (ctl_rdata[27]) busy_cnt++;
            @(negedge clk);
        end
    endtask

    initial begin
        int n;
        rst_n = 0; ctl_wr = 0; sts_wr = 0; ctl_wdata = 0; sts_wdata = 0;
        phy_link = 0; compare_on = 0;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(ctl_rdata == 0 && sts_rdata == 0, "R1 registers", ctl_rdata | sts_rdata, 0);
        chk(!mdc && !mdio_oe && !irq, "R1 pins", {mdc, mdio_oe, irq}, 0);
        rst_n = 1; compare_on = 1;
        @(negedge clk);
        chk(ctl_rdata == 0 && !mdc && !irq, "R1 after release", ctl_rdata, 0);

        sts_put(32'h0005_0000);
        // R2 R5: write frame with preamble, code 0 -> 4 cycles per bit
        ctl_put(mk(0, 3'd0, 1, 0, 0, 5'd3, 16'hA5C3));
        chk(ctl_rdata[23] == 1, "R6 start visible", ctl_rdata[23], 1);
        wait_idle(n);
        chk(n == 256, "R2 R5 write frame length", n, 256);

        // R3 R4 R5: read, no preamble, code 2 -> 12 cycles per bit
        ctl_put(mk(0, 3'd2, 1, 1, 1, 5'd7, 16'h0));
        wait_idle(n);
        chk(n == 384, "R4 R5 read frame length", n, 384);
        chk(ctl_rdata[15:0] == phy_reg_val(5'd5, 5'd7), "R3 read data", ctl_rdata[15:0], phy_reg_val(5'd5, 5'd7));

        // R5: code 7 -> 28 cycles per bit
        ctl_put(mk(0, 3'd7, 1, 1, 0, 5'd9, 16'h1234));
        wait_idle(n);
        chk(n == 896, "R5 code 7 length", n, 896);

        // R7: second write while start is pending is ignored
        ctl_put(mk(0, 3'd0, 1, 1, 0, 5'd4, 16'h0F0F));
        ctl_put(mk(0, 3'd1, 0, 0, 1, 5'd11, 16'hFFFF));
        wait_idle(n);
        chk(ctl_rdata[20:16] == 5'd4 && ctl_rdata[15:0] == 16'h0F0F && n == 128,
            "R7 ignored write", ctl_rdata, {16'h0004, 16'h0F0F});

        // R12: spare bits read back
        ctl_put(32'hE000_0000);
        chk(ctl_rdata == 32'h6000_0000, "R12 readback", ctl_rdata, 32'h6000_0000);

        // R8 R9: autopoll with no link change leaves irq low
        ctl_put(mk(1, 3'd0, 0, 1, 0, 5'd0, 16'h0));
        repeat (400) @(negedge clk);
        chk(!irq && ctl_rdata[27], "R8 R9 polling without change", {irq, ctl_rdata[27]}, 1);
        phy_link = 1;
        n = 0;
        while (!irq && n < 1000) begin @(negedge clk); n++; end
        chk(irq && sts_rdata[1], "R9 link up sets flag", sts_rdata[1:0], 3);

        // R10: clear by writing 1
        sts_put(32'h0005_0001);
        chk(!irq, "R10 clear", irq, 0);

        // R10: clear in the cycle the changed poll completes
        phy_link = 0;
        while (m_active) @(negedge clk);
        while (!m_active) @(negedge clk);
        while (q.size() != 1) @(negedge clk);
        sts_put(32'h0005_0001);
        chk(irq && !sts_rdata[1], "R10 set wins over clear", sts_rdata[1:0], 1);
        sts_put(32'h0005_0001);

        // R11: read queued mid-poll, with autopoll cleared in the same write
        while (!(m_active && !m_swact && q.size() > 40)) @(negedge clk);
        ctl_put(mk(0, 3'd0, 1, 1, 1, 5'd2, 16'h0));
        chk(ctl_rdata[27] && ctl_rdata[23], "R11 busy and start held", ctl_rdata[27:23], 5'h11);
        wait_idle(n);
        chk(ctl_rdata[15:0] == phy_reg_val(5'd5, 5'd2), "R11 queued read data", ctl_rdata[15:0], phy_reg_val(5'd5, 5'd2));
        repeat (20) @(negedge clk);
        chk(!ctl_rdata[27] && !mdio_oe, "R8 polling stops", ctl_rdata[27], 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule